// File: doc/BRIEF.md
# Exception and Interrupt Entry Unit

This block holds the control-coprocessor state of a small 32-bit RISC core at the moment control leaves the normal instruction stream: the status word, the cause word, the saved return address and the processor identity word, together with the program counter redirect. Each clock cycle it checks for a synchronous exception request from the pipeline and for a pending external interrupt. When either is present it performs a single entry. The entry updates the cause word, saves the return address and pushes the mode/enable stack held in the low status bits. It then loads the program counter with one of two vector addresses and raises a one-cycle redirect strobe.

The pipeline supplies the exception code, the address of the current instruction and a flag that says the instruction sits in a branch delay slot. An external interrupt controller supplies its status and mask words. Software can write the status and cause words directly through a shared write-data port when no entry is happening.

Top module: `exc_entry_unit`

## Requirements
- R1: Reset loads pc_o = 0xBFC00000, status_o = 0x10900000, cause_o = 0, epc_o = 0 and redirect_o = 0. prid_o reads 0x00000002 at all times.
- R2: On entry, cause_o becomes (old cause AND 0x00000300) OR the selected code, so bits 9:8 are the only old bits kept.
- R3: On entry with exc_in_delay = 1, cause_o bit 31 is set and epc_o = cur_pc - 4, wrapping modulo 2^32. With exc_in_delay = 0, epc_o = cur_pc and bit 31 comes only from the code.
- R4: On entry the new pc_o is 0xBFC00180 when status bit 22 was set before the entry, and 0x80000080 when it was clear.
- R5: On entry status bits 5:0 become the old bits 3:0 shifted left by two, with zeros in bits 1:0. Status bits 31:6 are unchanged.
- R6: An interrupt entry with code 0x00000400 occurs when (irq_status AND irq_mask) is non-zero and status bits 10 and 0 are both set. If either gate bit is clear, or the AND is zero, no entry occurs.
- R7: When exc_req and an interrupt are present in the same cycle, exactly one entry occurs, and it uses exc_code rather than 0x400.
- R8: redirect_o is high for exactly the one cycle after each entry. In cycles without an entry, pc_o and epc_o keep their values.
- R9: sw_status_we and sw_cause_we load sw_wdata into status or cause in cycles without an entry. In a cycle with an entry, both writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 32 | Cause code merged into cause on a requested entry |
| exc_in_delay | input | 1 | Current instruction sits in a branch delay slot |
| cur_pc | input | 32 | Address of the current instruction |
| irq_status | input | IRQ_W (11) | Interrupt controller status word |
| irq_mask | input | IRQ_W (11) | Interrupt controller mask word |
| sw_status_we | input | 1 | Software write enable for status |
| sw_cause_we | input | 1 | Software write enable for cause |
| sw_wdata | input | 32 | Software write data |
| pc_o | output | 32 | Program counter, holds the vector after an entry |
| redirect_o | output | 1 | One-cycle strobe that accompanies a new pc_o |
| status_o | output | 32 | Status word |
| cause_o | output | 32 | Cause word |
| epc_o | output | 32 | Saved return address |
| prid_o | output | 32 | Processor identity word |

## Verification
The bench builds the unit with its default parameters: 32-bit words, an 11-line interrupt vector, the boot-vector select at status bit 22, the interrupt gates at bits 10 and 0, and a six-bit stack pushed by two. These settings allow both vector addresses to be reached from one sequence. They also let cur_pc = 0 in a delay slot show the EPC wrap to 0xFFFFFFFC, and let three nested entries empty the stack completely. The same settings expose the case where an interrupt, once taken, cannot immediately re-enter, because the push clears the current enable bit.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN = 32;

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        word_t pc;
        word_t status;
        word_t cause;
        word_t epc;
        logic  redirect;
    } cp0_state_t;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
    parameter int IRQ_W = 11
) (
    input  logic [IRQ_W-1:0] irq_status,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic             gate_line,
    input  logic             gate_global,
    output logic             irq_hit
);
    logic [IRQ_W-1:0] active;

    always_comb begin
        active  = irq_status & irq_mask;
        irq_hit = (|active) & gate_line & gate_global;
    end

endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
#(
    parameter word_t INT_CODE = 32'h0000_0400
) (
    input  logic  exc_req,
    input  word_t exc_code,
    input  logic  irq_hit,
    output logic  take,
    output word_t code_sel
);
    always_comb begin
        take     = exc_req | irq_hit;
        code_sel = exc_req ? exc_code : INT_CODE;
    end

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter int    STK_W     = 6,
    parameter int    PUSH      = 2,
    parameter int    BEV_BIT   = 22,
    parameter int    BD_BIT    = 31,
    parameter word_t KEEP_MASK = 32'h0000_0300,
    parameter word_t PC_STEP   = 32'd4,
    parameter word_t VEC_BOOT  = 32'hBFC0_0180,
    parameter word_t VEC_NORM  = 32'h8000_0080
) (
    input  word_t status_q,
    input  word_t cause_q,
    input  word_t code_sel,
    input  logic  in_delay,
    input  word_t cur_pc,
    output word_t status_new,
    output word_t cause_new,
    output word_t epc_new,
    output word_t vector
);
    localparam word_t BD_MASK = word_t'(1) << BD_BIT;

    always_comb begin
        cause_new = (cause_q & KEEP_MASK) | code_sel;
        if (in_delay) begin
            cause_new = cause_new | BD_MASK;
            epc_new   = cur_pc - PC_STEP;
        end else begin
            epc_new   = cur_pc;
        end
        vector     = status_q[BEV_BIT] ? VEC_BOOT : VEC_NORM;
        status_new = {status_q[XLEN-1:STK_W], status_q[STK_W-PUSH-1:0], {PUSH{1'b0}}};
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int    IRQ_W       = 11,
    parameter int    STK_W       = 6,
    parameter int    PUSH        = 2,
    parameter int    BEV_BIT     = 22,
    parameter int    BD_BIT      = 31,
    parameter int    GATE_LINE   = 10,
    parameter int    GATE_GLOBAL = 0,
    parameter word_t KEEP_MASK   = 32'h0000_0300,
    parameter word_t INT_CODE    = 32'h0000_0400,
    parameter word_t PC_STEP     = 32'd4,
    parameter word_t VEC_BOOT    = 32'hBFC0_0180,
    parameter word_t VEC_NORM    = 32'h8000_0080,
    parameter word_t RESET_PC    = 32'hBFC0_0000,
    parameter word_t RESET_STAT  = 32'h1090_0000,
    parameter word_t PRID_VALUE  = 32'h0000_0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [31:0]      exc_code,
    input  logic             exc_in_delay,
    input  logic [31:0]      cur_pc,
    input  logic [IRQ_W-1:0] irq_status,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic             sw_status_we,
    input  logic             sw_cause_we,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      pc_o,
    output logic             redirect_o,
    output logic [31:0]      status_o,
    output logic [31:0]      cause_o,
    output logic [31:0]      epc_o,
    output logic [31:0]      prid_o
);
    localparam word_t BD_MASK   = word_t'(1) << BD_BIT;
    localparam word_t CODE_ONLY = ~(KEEP_MASK | BD_MASK);

    cp0_state_t state_d, state_q;

    logic  irq_hit;
    logic  take;
    word_t code_sel;
    word_t status_new, cause_new, epc_new, vector;

    exc_irq_gate #(.IRQ_W(IRQ_W)) u_gate (
        .irq_status (irq_status),
        .irq_mask   (irq_mask),
        .gate_line  (state_q.status[GATE_LINE]),
        .gate_global(state_q.status[GATE_GLOBAL]),
        .irq_hit    (irq_hit)
    );

    exc_select #(.INT_CODE(INT_CODE)) u_sel (
        .exc_req (exc_req),
        .exc_code(exc_code),
        .irq_hit (irq_hit),
        .take    (take),
        .code_sel(code_sel)
    );

    exc_entry_calc #(
        .STK_W    (STK_W),
        .PUSH     (PUSH),
        .BEV_BIT  (BEV_BIT),
        .BD_BIT   (BD_BIT),
        .KEEP_MASK(KEEP_MASK),
        .PC_STEP  (PC_STEP),
        .VEC_BOOT (VEC_BOOT),
        .VEC_NORM (VEC_NORM)
    ) u_calc (
        .status_q  (state_q.status),
        .cause_q   (state_q.cause),
        .code_sel  (code_sel),
        .in_delay  (exc_in_delay),
        .cur_pc    (cur_pc),
        .status_new(status_new),
        .cause_new (cause_new),
        .epc_new   (epc_new),
        .vector    (vector)
    );

    always_comb begin
        state_d          = state_q;
        state_d.redirect = 1'b0;
        if (take) begin
            state_d.pc       = vector;
            state_d.status   = status_new;
            state_d.cause    = cause_new;
            state_d.epc      = epc_new;
            state_d.redirect = 1'b1;
        end else begin
            if (sw_status_we) state_d.status = sw_wdata;
            if (sw_cause_we)  state_d.cause  = sw_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc       <= RESET_PC;
            state_q.status   <= RESET_STAT;
            state_q.cause    <= '0;
            state_q.epc      <= '0;
            state_q.redirect <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign redirect_o = state_q.redirect;
    assign status_o   = state_q.status;
    assign cause_o    = state_q.cause;
    assign epc_o      = state_q.epc;
    assign prid_o     = PRID_VALUE;

    a_r2_keep_sw_bits: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((cause_o & KEEP_MASK) == (($past(cause_o) | $past(code_sel)) & KEEP_MASK)));

    a_r3_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (take && exc_in_delay) |=> (epc_o == $past(cur_pc) - PC_STEP) && cause_o[BD_BIT]);

    a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pc_o == ($past(status_o[BEV_BIT]) ? VEC_BOOT : VEC_NORM)));

    a_r5_stack_push: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (status_o[STK_W-1:0] == {$past(status_o[STK_W-PUSH-1:0]), {PUSH{1'b0}}})
                 && (status_o[XLEN-1:STK_W] == $past(status_o[XLEN-1:STK_W])));

    a_r6_irq_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hit && !exc_req) |=> redirect_o && ((cause_o & CODE_ONLY) == (INT_CODE & CODE_ONLY)));

    a_r7_request_wins: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> redirect_o && ((cause_o & CODE_ONLY) == ($past(exc_code) & CODE_ONLY)));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !redirect_o && $stable(pc_o) && $stable(epc_o));

endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;

    typedef struct packed {
        logic [31:0] st_in;
        logic [31:0] ca_in;
        logic [31:0] code;
        logic        dly;
        logic [31:0] pc;
        logic [31:0] e_pc;
        logic [31:0] e_st;
        logic [31:0] e_ca;
        logic [31:0] e_epc;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0024, 1'b0, 32'h0000_1000,
          32'h8000_0080, 32'h0000_0000, 32'h0000_0024, 32'h0000_1000},
        '{32'h0040_000F, 32'h0000_0300, 32'h0000_0010, 1'b1, 32'h8001_0008,
          32'hBFC0_0180, 32'h0040_003C, 32'h8000_0310, 32'h8001_0004},
        '{32'h0040_0035, 32'h0000_F2FF, 32'h0000_007C, 1'b0, 32'h0000_0004,
          32'hBFC0_0180, 32'h0040_0014, 32'h0000_027C, 32'h0000_0004},
        '{32'h1000_0402, 32'h0000_0100, 32'h0000_0008, 1'b1, 32'h0000_0000,
          32'h8000_0080, 32'h1000_0408, 32'h8000_0108, 32'hFFFF_FFFC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [31:0] exc_code = '0;
    logic        exc_in_delay = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [10:0] irq_status = '0;
    logic [10:0] irq_mask = '0;
    logic        sw_status_we = 1'b0;
    logic        sw_cause_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] pc_o, status_o, cause_o, epc_o, prid_o;
    logic        redirect_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    exc_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_in_delay(exc_in_delay), .cur_pc(cur_pc), .irq_status(irq_status),
        .irq_mask(irq_mask), .sw_status_we(sw_status_we), .sw_cause_we(sw_cause_we),
        .sw_wdata(sw_wdata), .pc_o(pc_o), .redirect_o(redirect_o), .status_o(status_o),
        .cause_o(cause_o), .epc_o(epc_o), .prid_o(prid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_status(input logic [31:0] v);
        @(negedge clk); sw_status_we = 1'b1; sw_wdata = v;
        @(negedge clk); sw_status_we = 1'b0;
    endtask

    task automatic wr_cause(input logic [31:0] v);
        @(negedge clk); sw_cause_we = 1'b1; sw_wdata = v;
        @(negedge clk); sw_cause_we = 1'b0;
    endtask

    task automatic enter(input logic [31:0] code, input logic dly, input logic [31:0] pc);
        exc_req = 1'b1; exc_code = code; exc_in_delay = dly; cur_pc = pc;
        @(negedge clk);
        exc_req = 1'b0; exc_in_delay = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 pc", pc_o, 32'hBFC0_0000);
        chk("R1 status", status_o, 32'h1090_0000);
        chk("R1 cause", cause_o, 32'h0);
        chk("R1 epc", epc_o, 32'h0);
        chk("R1 redirect", {31'b0, redirect_o}, 32'h0);
        chk("R1 prid", prid_o, 32'h2);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr_status(VECS[i].st_in);
            wr_cause(VECS[i].ca_in);
            enter(VECS[i].code, VECS[i].dly, VECS[i].pc);
            chk("R4 vector", pc_o, VECS[i].e_pc);
            chk("R5 status push", status_o, VECS[i].e_st);
            chk("R2/R3 cause", cause_o, VECS[i].e_ca);
            chk("R3 epc", epc_o, VECS[i].e_epc);
            chk("R8 strobe high", {31'b0, redirect_o}, 32'h1);
            @(negedge clk);
            chk("R8 strobe low", {31'b0, redirect_o}, 32'h0);
        end

        // R5 nested entries drain the stack
        wr_status(32'h0000_0003);
        enter(32'h0, 1'b0, 32'h100);
        chk("R5 nest1", status_o, 32'h0000_000C);
        enter(32'h0, 1'b0, 32'h104);
        chk("R5 nest2", status_o, 32'h0000_0030);
        enter(32'h0, 1'b0, 32'h108);
        chk("R5 nest3", status_o, 32'h0000_0000);

        // R6 interrupt taken
        wr_cause(32'h0);
        wr_status(32'h0000_0401);
        cur_pc = 32'h0000_1234;
        irq_status = 11'h008; irq_mask = 11'h008;
        @(negedge clk);
        chk("R6 irq strobe", {31'b0, redirect_o}, 32'h1);
        chk("R6 irq cause", cause_o, 32'h0000_0400);
        chk("R6 irq status", status_o, 32'h0000_0404);
        chk("R6 irq epc", epc_o, 32'h0000_1234);
        chk("R6 irq pc", pc_o, 32'h8000_0080);
        @(negedge clk);
        chk("R6 no reentry", {31'b0, redirect_o}, 32'h0);

        // R6 masked by bit 10 clear
        irq_status = '0;
        wr_status(32'h0000_0001);
        irq_status = 11'h008;
        @(negedge clk); @(negedge clk);
        chk("R6 gate bit10 strobe", {31'b0, redirect_o}, 32'h0);
        chk("R6 gate bit10 cause", cause_o, 32'h0000_0400);
        chk("R6 gate bit10 status", status_o, 32'h0000_0001);

        // R6 masked by bit 0 clear
        irq_status = '0;
        wr_status(32'h0000_0400);
        irq_status = 11'h008;
        @(negedge clk); @(negedge clk);
        chk("R6 gate bit0 strobe", {31'b0, redirect_o}, 32'h0);
        chk("R6 gate bit0 status", status_o, 32'h0000_0400);

        // R6 mask word zero
        irq_status = '0;
        wr_status(32'h0000_0401);
        irq_status = 11'h008; irq_mask = 11'h000;
        @(negedge clk); @(negedge clk);
        chk("R6 mask zero", status_o, 32'h0000_0401);

        // R7 request beats interrupt
        irq_mask = 11'h008;
        enter(32'h0000_0020, 1'b0, 32'h0000_2000);
        chk("R7 code", cause_o, 32'h0000_0020);
        chk("R7 status", status_o, 32'h0000_0404);
        @(negedge clk);
        chk("R7 single entry", {31'b0, redirect_o}, 32'h0);
        irq_status = '0; irq_mask = '0;

        // R9 software writes ignored during entry, honoured otherwise
        wr_status(32'h0);
        wr_cause(32'h0);
        sw_status_we = 1'b1; sw_cause_we = 1'b1; sw_wdata = 32'hFFFF_FFFF;
        enter(32'h0000_000C, 1'b0, 32'h0000_3000);
        sw_status_we = 1'b0; sw_cause_we = 1'b0;
        chk("R9 status ignored", status_o, 32'h0);
        chk("R9 cause ignored", cause_o, 32'h0000_000C);
        wr_cause(32'h0000_0300);
        chk("R9 cause written", cause_o, 32'h0000_0300);
        chk("R8 pc held", pc_o, 32'h8000_0080);
        chk("R1 prid stable", prid_o, 32'h2);

        finish_run();
    end

endmodule